// File: doc/BRIEF.md
# Replay-capable FIFO buffer with hysteretic half-full flag

This block is a single-clock first-in first-out store for 9-bit words. A producer pushes a word by pulling an active-low write strobe low, and a consumer pulls a word by holding an active-low read strobe low. Each strobe's falling edge is turned into a one-cycle internal event. The read pointer moves on when the read strobe is released. The block keeps its own write and read pointers. It reports occupancy through three active-low flags: empty, full, and a half-full flag that has hysteresis.

An active-low rewind input moves the read pointer back to location zero and leaves the write pointer where it is. The words written since the last reset can then be read out again, for example after the far end reports a corrupted transfer.

The output bus is modelled as a data word plus an enable, not as a tri-state bus. If a read is started on an empty buffer, the read waits. The first word that arrives is then passed straight to the output.

The read side has four states:
- `RD_IDLE`: no read in progress.
- `RD_LIVE`: a read started on a buffer that held data.
- `RD_STARVE`: a read started on an empty buffer and is waiting.
- `RD_FLOW`: a waiting read has received a word.

The read side moves between these states as follows:
- IDLE to LIVE on a read edge while data is present.
- IDLE to STARVE on a read edge while the buffer is empty.
- IDLE to FLOW on a read edge in the same cycle as a write into an empty buffer.
- STARVE to FLOW on an accepted write.
- LIVE, STARVE or FLOW back to IDLE when the read strobe rises.

The half-full tracker has two states, `HF_BELOW` and `HF_ABOVE`:
- BELOW to ABOVE on an accepted write that finds at least DEPTH/2 words stored.
- ABOVE to BELOW on a read completion that leaves at most DEPTH/2 words.
- A rewind loads either state from the recomputed occupancy.

Top module: `rtx_fifo`

## Requirements
- R1: A synchronous low level on `rst_n` puts both pointers at location zero. On the first sampled edge after reset, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_en`=0.
- R2: A falling edge of `wr_n`, seen at a clock edge, stores `din` when the buffer is not full. Words are read out in the order they were written.
- R3: While the buffer is full (`full_n`=0), write edges are ignored. Stored data and the write pointer do not change, and occupancy never exceeds DEPTH.
- R4: A read edge on an empty buffer does not move the read pointer. `dout_en` stays 0 until a word arrives.
- R5: With no reads since reset, `full_n` goes to 0 after exactly DEPTH accepted writes. It returns to 1 in the cycle after a read completes.
- R6: `empty_n` is 0 exactly when the read pointer equals the write pointer. It goes to 1 in the cycle after a write is accepted into an empty buffer, and back to 0 after the read that takes the last word completes.
- R7: `half_n` goes to 0 on an accepted write that finds at least DEPTH/2 words stored. It stays 0 until a read completion leaves at most DEPTH/2 words.
- R8: A falling edge of `rewind_n` is accepted when both strobes are high and no read is in progress. It then sets the read pointer to zero and keeps the write pointer. Reads replay from the first word written, and all three flags are recomputed from the new occupancy.
- R9: A rewind edge that arrives while either strobe is low has no effect on the read pointer.
- R10: When a read is held on an empty buffer and a word is written, `dout_en` goes to 1 with that word on `dout`. Further writes during the same read do not change `dout`. The read pointer advances only when the read strobe is released.
- R11: `dout_en` is 1 only while a read is presenting a stored word. It falls in the cycle after `rd_n` returns high, and the read pointer advances at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe, falling edge stores a word |
| rd_n | input | 1 | Active-low read strobe, held low for the read, release completes it |
| rewind_n | input | 1 | Active-low rewind request, falling edge acts |
| din | input | DATA_W | Word to store |
| dout | output | DATA_W | Word at the read pointer |
| dout_en | output | 1 | High while `dout` carries a word for the current read |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low while the buffer is more than half full, with hysteresis |

## Verification
The bench builds the block with DEPTH=8 and 9-bit words. With these values the half-full threshold of four words and the full condition after eight writes are reached in a few dozen cycles. A replay run also stays within one depth of writes since reset, which is the only range in which rewinding gives meaningful data. The small depth also lets the bench fill the buffer, test write blocking, replay through a rewind, and then drain through a flow-through read within one short run.

// File: rtl/rtx_fifo_pkg.sv
`timescale 1ns/1ps
package rtx_fifo_pkg;

    // Read-side controller states
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_LIVE   = 2'd1,
        RD_STARVE = 2'd2,
        RD_FLOW   = 2'd3
    } rd_state_e;

    // Half-full hysteresis states
    typedef enum logic {
        HF_BELOW = 1'b0,
        HF_ABOVE = 1'b1
    } half_state_e;

endpackage

// File: rtl/rtx_strobe_edge.sv
`timescale 1ns/1ps
// Turns one transition of an active-low strobe into a one-cycle pulse.
module rtx_strobe_edge #(
    parameter bit RISING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic hit
);

    logic prev_q;

    // Previous level starts high so a strobe held low through reset
    // registers as a fresh falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= strobe_n;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign hit = !prev_q && strobe_n;
        end else begin : g_fall
            assign hit = prev_q && !strobe_n;
        end
    endgenerate

endmodule

// File: rtl/rtx_fifo_mem.sv
`timescale 1ns/1ps
// Storage array with a registered write port and a combinational read port.
module rtx_fifo_mem #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/rtx_fifo_ptrs.sv
`timescale 1ns/1ps
// Pointer pair, occupancy, empty/full flags and the half-full hysteresis FSM.
module rtx_fifo_ptrs
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fall,
    input  logic              rd_done,
    input  logic              rewind_ok,
    output logic              wr_take,
    output logic [PTR_W-1:0]  wptr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  occ,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);

    localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_OCC = PTR_W'(DEPTH / 2);

    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] occ_after_rd;
    half_state_e      half_q;
    half_state_e      half_d;
    half_state_e      half_rewind;

    // Extra pointer bit separates full from empty at equal addresses.
    assign occ          = wptr - rptr;
    assign wr_take      = wr_fall && (occ != FULL_OCC);
    assign occ_after_rd = occ - PTR_W'(1) + PTR_W'(wr_take);
    assign rd_addr      = rptr[ADDR_W-1:0];

    // After a rewind the read pointer is zero, so occupancy is the write pointer.
    assign half_rewind  = (wptr > HALF_OCC) ? HF_ABOVE : HF_BELOW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_take) begin
                wptr <= wptr + PTR_W'(1);
            end
            if (rewind_ok) begin
                rptr <= '0;
            end else if (rd_done) begin
                rptr <= rptr + PTR_W'(1);
            end
        end
    end

    // Half-full state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HF_BELOW;
        end else begin
            half_q <= half_d;
        end
    end

    // Half-full transitions
    always_comb begin
        half_d = half_q;
        unique case (half_q)
            HF_BELOW: begin
                if (rewind_ok) begin
                    half_d = half_rewind;
                end else if (wr_take && (occ >= HALF_OCC)) begin
                    half_d = HF_ABOVE;
                end
            end
            HF_ABOVE: begin
                if (rewind_ok) begin
                    half_d = half_rewind;
                end else if (rd_done && (occ_after_rd <= HALF_OCC)) begin
                    half_d = HF_BELOW;
                end
            end
        endcase
    end

    // Flag outputs
    always_comb begin
        empty_n = (occ != '0);
        full_n  = (occ != FULL_OCC);
        unique case (half_q)
            HF_BELOW: half_n = 1'b1;
            HF_ABOVE: half_n = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtx_fifo_rdctl.sv
`timescale 1ns/1ps
// Read-side controller: normal reads, starved reads and flow-through.
module rtx_fifo_rdctl
    import rtx_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_fall,
    input  logic rd_rise,
    input  logic is_empty,
    input  logic wr_take,
    output logic rd_done,
    output logic word_on,
    output logic rd_idle
);

    rd_state_e state_q;
    rd_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: begin
                if (rd_fall) begin
                    if (!is_empty) begin
                        state_d = RD_LIVE;
                    end else if (wr_take) begin
                        state_d = RD_FLOW;
                    end else begin
                        state_d = RD_STARVE;
                    end
                end
            end
            RD_LIVE: begin
                if (rd_rise) begin
                    state_d = RD_IDLE;
                end
            end
            RD_STARVE: begin
                if (rd_rise) begin
                    state_d = RD_IDLE;
                end else if (wr_take) begin
                    state_d = RD_FLOW;
                end
            end
            RD_FLOW: begin
                if (rd_rise) begin
                    state_d = RD_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        rd_done = 1'b0;
        word_on = 1'b0;
        rd_idle = 1'b0;
        unique case (state_q)
            RD_IDLE: begin
                rd_idle = 1'b1;
            end
            RD_LIVE, RD_FLOW: begin
                word_on = 1'b1;
                rd_done = rd_rise;
            end
            RD_STARVE: begin
                word_on = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rtx_fifo.sv
`timescale 1ns/1ps
// Top level: strobe edge detection, pointer/flag unit, read controller, storage.
module rtx_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rewind_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int N_EDGE = 4;
    // Detector slots: 0 write fall, 1 read fall, 2 read rise, 3 rewind fall
    localparam logic [N_EDGE-1:0] EDGE_RISING = 4'b0100;

    logic [N_EDGE-1:0] edge_src;
    logic [N_EDGE-1:0] edge_hit;
    logic              wr_fall;
    logic              rd_fall;
    logic              rd_rise;
    logic              rew_fall;
    logic              wr_take;
    logic              rd_done;
    logic              rd_idle;
    logic              rewind_ok;
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  occ;
    logic [ADDR_W-1:0] rd_addr;

    assign edge_src = {rewind_n, rd_n, rd_n, wr_n};

    genvar g;
    generate
        for (g = 0; g < N_EDGE; g++) begin : g_edge
            rtx_strobe_edge #(
                .RISING (EDGE_RISING[g])
            ) edge_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe_n (edge_src[g]),
                .hit      (edge_hit[g])
            );
        end
    endgenerate

    assign wr_fall  = edge_hit[0];
    assign rd_fall  = edge_hit[1];
    assign rd_rise  = edge_hit[2];
    assign rew_fall = edge_hit[3];

    // Rewind acts only with both strobes idle and no read outstanding.
    assign rewind_ok = rew_fall && wr_n && rd_n && rd_idle;

    rtx_fifo_ptrs #(
        .DEPTH (DEPTH)
    ) ptrs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fall   (wr_fall),
        .rd_done   (rd_done),
        .rewind_ok (rewind_ok),
        .wr_take   (wr_take),
        .wptr      (wptr),
        .rd_addr   (rd_addr),
        .occ       (occ),
        .empty_n   (empty_n),
        .full_n    (full_n),
        .half_n    (half_n)
    );

    rtx_fifo_rdctl rdctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fall  (rd_fall),
        .rd_rise  (rd_rise),
        .is_empty (!empty_n),
        .wr_take  (wr_take),
        .rd_done  (rd_done),
        .word_on  (dout_en),
        .rd_idle  (rd_idle)
    );

    rtx_fifo_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) mem_i (
        .clk   (clk),
        .we    (wr_take),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (din),
        .raddr (rd_addr),
        .rdata (dout)
    );

endmodule

// File: rtl/rtx_fifo_chk.sv
`timescale 1ns/1ps
// Temporal checks for rtx_fifo, attached by bind.
module rtx_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_n,
    input logic             rd_n,
    input logic             rewind_n,
    input logic             empty_n,
    input logic             full_n,
    input logic             half_n,
    input logic             dout_en,
    input logic [PTR_W-1:0] occ,
    input logic [PTR_W-1:0] wptr
);

    localparam logic [PTR_W-1:0] HALF_OCC = PTR_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH);

    logic wr_q;
    logic rd_q;
    logic rew_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b1;
            rd_q  <= 1'b1;
            rew_q <= 1'b1;
        end else begin
            wr_q  <= wr_n;
            rd_q  <= rd_n;
            rew_q <= rewind_n;
        end
    end

    logic wr_fall_c;
    logic rd_rise_c;
    logic rew_fall_c;
    assign wr_fall_c  = wr_q && !wr_n;
    assign rd_rise_c  = !rd_q && rd_n;
    assign rew_fall_c = rew_q && !rewind_n;

    always @(posedge clk) begin
        if (rst_n) begin
            a_occ_bound_r3: assert (occ <= FULL_OCC)
                else $error("occupancy above depth");
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_rise_c && !rew_fall_c) |=> !full_n)
        else $error("full flag dropped without a read");

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_fall_c && !rew_fall_c) |=> !empty_n)
        else $error("empty flag dropped without a write");

    p_full_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && rd_rise_c && !wr_fall_c) |=> full_n)
        else $error("full flag held after a completed read");

    p_fill_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wr_fall_c) |=> empty_n)
        else $error("write into empty buffer not reflected");

    p_half_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fall_c && full_n && (occ >= HALF_OCC) && !rd_rise_c) |=> !half_n)
        else $error("half flag not set by write past half");

    p_rewind_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rew_fall_c && wr_n && rd_n && rd_q) |=> (occ == $past(wptr)))
        else $error("rewind did not restart read pointer");

    p_en_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && rd_n) |=> !dout_en)
        else $error("output enable stayed after read release");

endmodule

bind rtx_fifo rtx_fifo_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/rtx_fifo_tb_top.sv
`timescale 1ns/1ps
module rtx_fifo_tb_top;

    localparam int D = 8;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         rewind_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_en;
    logic         empty_n;
    logic         full_n;
    logic         half_n;

    always #2 clk = ~clk;

    rtx_fifo #(.DATA_W(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .rewind_n(rewind_n), .din(din), .dout(dout), .dout_en(dout_en),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    int           n_chk = 0;
    int           n_bad = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] m_mem [0:D-1];
    int           m_w = 0;
    int           m_r = 0;
    bit           r_live = 0;
    bit           en_q = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic chk_flags(input bit e, input bit f, input bit h, input string tag);
        chk(empty_n == e, {tag, " empty_n"}, int'(empty_n), int'(e));
        chk(full_n == f,  {tag, " full_n"},  int'(full_n),  int'(f));
        chk(half_n == h,  {tag, " half_n"},  int'(half_n),  int'(h));
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: each new output window pops one expected word.
    always @(negedge clk) begin : mon
        logic [W-1:0] e;
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            if (dout_en && !en_q) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R2 unexpected word actual=%0h expected=none", dout);
                end else begin
                    e = exp_q.pop_front();
                    chk(dout == e, "R2 read order", int'(dout), int'(e));
                end
            end
            en_q <= dout_en;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        wr_n = 1'b1;
        rd_n = 1'b1;
        rewind_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_w = 0;
        m_r = 0;
        exp_q.delete();
        @(negedge clk);
    endtask

    // Driver: model acceptance and record the written word.
    task automatic do_write(input logic [W-1:0] v);
        wr_n = 1'b0;
        din = v;
        if (m_w - m_r < D) begin
            m_mem[m_w % D] = v;
            m_w++;
        end
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_begin();
        rd_n = 1'b0;
        if (m_w - m_r > 0) begin
            exp_q.push_back(m_mem[m_r % D]);
            r_live = 1'b1;
        end else begin
            r_live = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic rd_end();
        rd_n = 1'b1;
        if (r_live) m_r++;
        r_live = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_begin();
        if (!r_live) chk(dout_en == 1'b0, "R4 read on empty", int'(dout_en), 0);
        rd_end();
        chk(dout_en == 1'b0, "R11 enable after release", int'(dout_en), 0);
    endtask

    task automatic do_rewind();
        rewind_n = 1'b0;
        if (rd_n && wr_n) m_r = 0;
        @(negedge clk);
        rewind_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        // R1: reset state
        do_reset();
        chk_flags(1'b0, 1'b1, 1'b1, "R1 reset");
        chk(dout_en == 1'b0, "R1 reset dout_en", int'(dout_en), 0);

        // R2/R6: basic order and empty flag
        do_write(9'h101);
        chk(empty_n == 1'b1, "R6 after first write", int'(empty_n), 1);
        do_write(9'h0A5);
        do_write(9'h1FF);
        for (int i = 0; i < 3; i++) do_read();
        chk(empty_n == 1'b0, "R6 after last read", int'(empty_n), 0);

        // R4: read on empty leaves pointer in place
        do_read();
        do_write(9'h033);
        do_read();
        chk(exp_q.size() == 0, "R4 all words seen", exp_q.size(), 0);

        // R5/R7/R3: fill, half flag, overflow block
        do_reset();
        for (int i = 0; i < D; i++) begin
            do_write(W'(16'h11 + i * 37));
            if (i == 3) chk(half_n == 1'b1, "R7 at half", int'(half_n), 1);
            if (i == 4) chk(half_n == 1'b0, "R7 past half", int'(half_n), 0);
            if (i == D - 2) chk(full_n == 1'b1, "R5 one short of full", int'(full_n), 1);
        end
        chk(full_n == 1'b0, "R5 full after depth writes", int'(full_n), 0);
        do_write(9'h1EE);
        chk(full_n == 1'b0, "R3 full holds after blocked write", int'(full_n), 0);
        do_read();
        chk(full_n == 1'b1, "R5 full clears after read", int'(full_n), 1);
        do_read();
        do_read();
        chk(half_n == 1'b0, "R7 still above at five", int'(half_n), 0);
        do_read();
        chk(half_n == 1'b1, "R7 clears at half", int'(half_n), 1);
        for (int i = 0; i < 4; i++) do_read();
        chk(empty_n == 1'b0, "R3 drained, blocked word absent", int'(empty_n), 0);
        chk(exp_q.size() == 0, "R3 all words seen", exp_q.size(), 0);

        // R8: rewind replays and recomputes flags
        do_reset();
        for (int i = 0; i < 6; i++) do_write(W'(16'h40 + i * 23));
        do_read();
        do_read();
        chk(half_n == 1'b1, "R7 below before rewind", int'(half_n), 1);
        do_rewind();
        chk_flags(1'b1, 1'b1, 1'b0, "R8 after rewind");
        for (int i = 0; i < 6; i++) do_read();
        chk(empty_n == 1'b0, "R8 replay drained", int'(empty_n), 0);
        do_rewind();
        chk_flags(1'b1, 1'b1, 1'b0, "R8 rewind from empty");
        for (int i = 0; i < 3; i++) do_read();

        // R9: rewind during an active read is ignored
        rd_begin();
        rewind_n = 1'b0;
        @(negedge clk);
        rewind_n = 1'b1;
        @(negedge clk);
        rd_end();
        do_read();
        do_read();
        chk(empty_n == 1'b0, "R9 pointer kept its place", int'(empty_n), 0);
        chk(exp_q.size() == 0, "R9 all words seen", exp_q.size(), 0);

        // R10: flow-through on an empty buffer
        rd_begin();
        chk(dout_en == 1'b0, "R10 starved read", int'(dout_en), 0);
        wr_n = 1'b0;
        din = 9'h15A;
        m_mem[m_w % D] = 9'h15A;
        m_w++;
        exp_q.push_back(9'h15A);
        r_live = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        chk(dout_en == 1'b1, "R10 enable on arrival", int'(dout_en), 1);
        chk(dout == 9'h15A, "R10 word on arrival", int'(dout), 9'h15A);
        @(negedge clk);
        do_write(9'h0C3);
        chk(dout == 9'h15A, "R10 word held", int'(dout), 9'h15A);
        chk(dout_en == 1'b1, "R10 enable held", int'(dout_en), 1);
        rd_end();
        do_read();
        chk(empty_n == 1'b0, "R10 both words consumed", int'(empty_n), 0);

        // R1: reset with data stored
        do_write(9'h077);
        do_write(9'h088);
        do_reset();
        chk_flags(1'b0, 1'b1, 1'b1, "R1 reset with data");
        do_read();
        chk(exp_q.size() == 0, "R1 nothing pending", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule